// File: doc/BRIEF.md
# Stack-Checked Dual-Word Transfer Unit

This block is the execute-stage sequencer for a paired 32-bit load or store that uses an 8-bit immediate offset. When an operation is accepted, it captures the decoded fields and register values. In the next cycle it decides whether the operation may go ahead. If it may, it issues two word requests one after the other on a valid/ready port. It then presents the loaded words, the destination write enables and the updated base value together in a single completion cycle.

Before any request leaves the block, a stack-limit guard is applied. The guard applies only when checking is enabled and the operation both uses the stack pointer (register index 13) as its base and writes that base back. The address compared with the limit is the lower of the starting and ending stack pointer. A write-back that would move the pointer below the limit therefore faults, and so does one that starts below the limit and finishes above it. A fault, or a PC-based (index 15) write-back encoding, ends the operation at once. Neither case produces any access or any register update.

Top module: `dxg_top`

## Requirements
- R1: The byte offset is the immediate times 4, negated when the add bit `up_i` is 0. The first request address is base plus offset when `pre_i` is 1, and the unmodified base when `pre_i` is 0.
- R2: The second request address is the first request address plus 4, modulo 2^32.
- R3: A stack fault can only occur when `chk_en_i` is 1, `base_idx_i` is 13 and `wback_i` is 1. A stack-based access without write-back never faults.
- R4: The probe compared against the limit is base plus offset when the offset is negative, and the base otherwise. A pointer that starts below the limit and ends at or above it still faults.
- R5: The probe faults when it is unsigned-less-than `limit_i`. A probe equal to or above the limit passes.
- R6: `stk_fault_o` is a one-cycle pulse in the cycle after acceptance. On a fault, no request is issued, `wb_en_o`, `ld_we0_o` and `ld_we1_o` stay 0, and the unit is idle in the next cycle.
- R7: Base index 15 with write-back enabled raises a one-cycle `illegal_o` pulse in the cycle after acceptance. It issues no request and makes no register update.
- R8: When `wback_i` is 1 and the operation is allowed, `wb_en_o` is asserted with `wb_data_o` equal to base plus offset. This happens only in the completion cycle that follows the second accepted request.
- R9: For a load (`load_i` = 1), both requests have `mreq_we_o` = 0. The word returned for the first request appears on `ld_data0_o` and the second on `ld_data1_o`, with both enables set in the completion cycle. For a store, `mreq_we_o` = 1, the write data is `st_data0_i` and then `st_data1_i`, and no load enable is set.
- R10: While `mreq_valid_o` is 1 and `mreq_ready_i` is 0, the request stays valid with unchanged address and data.
- R11: After reset and between operations, `idle_o` is 1 and no request is valid. `idle_o` is 0 from the cycle after acceptance until the cycle after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (accepted while idle) |
| idle_o | output | 1 | Unit can accept an operation |
| chk_en_i | input | 1 | Stack-limit checking enable |
| base_idx_i | input | 4 | Base register index |
| imm_i | input | 8 | Word-scaled immediate |
| up_i | input | 1 | 1 = add offset, 0 = subtract |
| pre_i | input | 1 | 1 = apply offset before access |
| wback_i | input | 1 | Write updated base back |
| load_i | input | 1 | 1 = load, 0 = store |
| base_val_i | input | 32 | Base register value |
| limit_i | input | 32 | Stack-limit value |
| st_data0_i | input | 32 | Store word for first access |
| st_data1_i | input | 32 | Store word for second access |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request accepted |
| mreq_addr_o | output | 32 | Request byte address |
| mreq_we_o | output | 1 | Request is a write |
| mreq_wdata_o | output | 32 | Request write data |
| mresp_data_i | input | 32 | Read data, valid in the accepting cycle |
| ld_data0_o | output | 32 | Word loaded by first access |
| ld_data1_o | output | 32 | Word loaded by second access |
| ld_we0_o | output | 1 | First destination write enable |
| ld_we1_o | output | 1 | Second destination write enable |
| wb_data_o | output | 32 | Updated base value |
| wb_en_o | output | 1 | Base write enable |
| done_o | output | 1 | Completion pulse |
| stk_fault_o | output | 1 | Stack-limit fault pulse |
| illegal_o | output | 1 | Illegal-encoding pulse |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, an 8-bit immediate, the stack pointer at index 13 and the program counter at index 15. With these values an offset reaches up to ±1020 bytes. The bench therefore places random bases within about a kilobyte of the limit, so that start-below/end-above crossings, exact equality with the limit and wraparound through zero all come up. Random ready stalls keep each request pending for several cycles.

// File: rtl/dxg_pkg.sv
package dxg_pkg;

    localparam int XLEN       = 32;
    localparam int IMM_W      = 8;
    localparam int RIDX_W     = 4;
    localparam int WORD_BYTES = 4;
    localparam int SCALE_SH   = $clog2(WORD_BYTES);

    typedef struct packed {
        logic [RIDX_W-1:0] base_idx;
        logic [IMM_W-1:0]  imm;
        logic              up;
        logic              pre;
        logic              wback;
        logic              load;
    } dxg_op_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_ACC0  = 3'd2,
        ST_ACC1  = 3'd3,
        ST_DONE  = 3'd4
    } dxg_state_t;

    typedef struct packed {
        logic [XLEN-1:0] addr0;
        logic [XLEN-1:0] addr1;
        logic [XLEN-1:0] new_base;
        logic [XLEN-1:0] probe;
    } dxg_addr_t;

    // Signed word-scaled offset, two's complement in XLEN bits.
    function automatic logic [XLEN-1:0] scaled_offset(input logic [IMM_W-1:0] imm,
                                                      input logic up);
        logic [XLEN-1:0] mag;
        mag = XLEN'(imm) << SCALE_SH;
        return up ? mag : (~mag + 1'b1);
    endfunction

    // Lower of start and end pointer: end when moving down, start otherwise.
    function automatic logic [XLEN-1:0] lower_probe(input logic [XLEN-1:0] base,
                                                    input logic [XLEN-1:0] fin,
                                                    input logic up);
        return up ? base : fin;
    endfunction

endpackage

// File: rtl/dxg_addr_gen.sv
module dxg_addr_gen
    import dxg_pkg::*;
(
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             up_i,
    input  logic             pre_i,
    output dxg_addr_t        addrs_o
);
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] fin;

    always_comb begin
        offset           = scaled_offset(imm_i, up_i);
        fin              = base_i + offset;
        addrs_o.new_base = fin;
        addrs_o.addr0    = pre_i ? fin : base_i;
        addrs_o.addr1    = addrs_o.addr0 + XLEN'(WORD_BYTES);
        addrs_o.probe    = lower_probe(base_i, fin, up_i);
    end
endmodule

// File: rtl/dxg_limit_chk.sv
module dxg_limit_chk
    import dxg_pkg::*;
#(
    parameter int SP_IDX = 13,
    parameter int PC_IDX = 15
) (
    input  logic              chk_en_i,
    input  logic [RIDX_W-1:0] base_idx_i,
    input  logic              wback_i,
    input  logic [XLEN-1:0]   probe_i,
    input  logic [XLEN-1:0]   limit_i,
    output logic              fault_o,
    output logic              illegal_o
);
    localparam logic [RIDX_W-1:0] SP_CODE = RIDX_W'(SP_IDX);
    localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

    logic guard_on;
    logic below;

    always_comb begin
        guard_on  = chk_en_i && wback_i && (base_idx_i == SP_CODE);
        below     = probe_i < limit_i;
        illegal_o = wback_i && (base_idx_i == PC_CODE);
        fault_o   = guard_on && below && !illegal_o;
    end
endmodule

// File: rtl/dxg_seq.sv
module dxg_seq
    import dxg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    output logic            idle_o,
    input  logic            fault_i,
    input  logic            illegal_i,
    input  logic            load_i,
    input  logic            wback_i,
    input  logic [XLEN-1:0] addr0_i,
    input  logic [XLEN-1:0] addr1_i,
    input  logic [XLEN-1:0] new_base_i,
    input  logic [XLEN-1:0] st0_i,
    input  logic [XLEN-1:0] st1_i,
    output logic            mreq_valid_o,
    input  logic            mreq_ready_i,
    output logic [XLEN-1:0] mreq_addr_o,
    output logic            mreq_we_o,
    output logic [XLEN-1:0] mreq_wdata_o,
    input  logic [XLEN-1:0] mresp_data_i,
    output logic [XLEN-1:0] ld_data0_o,
    output logic [XLEN-1:0] ld_data1_o,
    output logic            ld_we0_o,
    output logic            ld_we1_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            wb_en_o,
    output logic            done_o,
    output logic            stk_fault_o,
    output logic            illegal_o
);
    dxg_state_t      state_q, state_d;
    logic [XLEN-1:0] ld0_q, ld1_q;
    logic            hs;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: state_d = (fault_i || illegal_i) ? ST_IDLE : ST_ACC0;
            ST_ACC0:  if (mreq_ready_i) state_d = ST_ACC1;
            ST_ACC1:  if (mreq_ready_i) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ld0_q   <= '0;
            ld1_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACC0 && mreq_ready_i && load_i) ld0_q <= mresp_data_i;
            if (state_q == ST_ACC1 && mreq_ready_i && load_i) ld1_q <= mresp_data_i;
        end
    end

    always_comb begin
        idle_o       = (state_q == ST_IDLE);
        mreq_valid_o = (state_q == ST_ACC0) || (state_q == ST_ACC1);
        mreq_addr_o  = (state_q == ST_ACC1) ? addr1_i : addr0_i;
        mreq_wdata_o = (state_q == ST_ACC1) ? st1_i : st0_i;
        mreq_we_o    = !load_i;
        hs           = mreq_valid_o && mreq_ready_i;
        done_o       = (state_q == ST_DONE);
        ld_we0_o     = done_o && load_i;
        ld_we1_o     = done_o && load_i;
        ld_data0_o   = ld0_q;
        ld_data1_o   = ld1_q;
        wb_en_o      = done_o && wback_i;
        wb_data_o    = new_base_i;
        stk_fault_o  = (state_q == ST_CHECK) && fault_i && !illegal_i;
        illegal_o    = (state_q == ST_CHECK) && illegal_i;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_wdata_o)); // R10
    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACC0) && hs |=> mreq_valid_o && (mreq_addr_o == $past(mreq_addr_o) + XLEN'(WORD_BYTES))); // R2
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        stk_fault_o |-> !mreq_valid_o && !wb_en_o && !ld_we0_o && !ld_we1_o); // R6
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        stk_fault_o |=> !stk_fault_o && idle_o && !mreq_valid_o); // R6
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> idle_o && !mreq_valid_o && !wb_en_o); // R7
endmodule

// File: rtl/dxg_top.sv
module dxg_top
    import dxg_pkg::*;
#(
    parameter int SP_IDX = 13,
    parameter int PC_IDX = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              idle_o,
    input  logic              chk_en_i,
    input  logic [RIDX_W-1:0] base_idx_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              up_i,
    input  logic              pre_i,
    input  logic              wback_i,
    input  logic              load_i,
    input  logic [XLEN-1:0]   base_val_i,
    input  logic [XLEN-1:0]   limit_i,
    input  logic [XLEN-1:0]   st_data0_i,
    input  logic [XLEN-1:0]   st_data1_i,
    output logic              mreq_valid_o,
    input  logic              mreq_ready_i,
    output logic [XLEN-1:0]   mreq_addr_o,
    output logic              mreq_we_o,
    output logic [XLEN-1:0]   mreq_wdata_o,
    input  logic [XLEN-1:0]   mresp_data_i,
    output logic [XLEN-1:0]   ld_data0_o,
    output logic [XLEN-1:0]   ld_data1_o,
    output logic              ld_we0_o,
    output logic              ld_we1_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              wb_en_o,
    output logic              done_o,
    output logic              stk_fault_o,
    output logic              illegal_o
);
    localparam logic [RIDX_W-1:0] SP_CODE = RIDX_W'(SP_IDX);

    dxg_op_t         op_q;
    logic [XLEN-1:0] base_q, limit_q, st0_q, st1_q;
    logic            chk_q;
    dxg_addr_t       addrs;
    logic            fault, illegal;
    logic            accept;

    assign accept = start_i && idle_o;

    // Operand capture on acceptance; held for the whole operation.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= '0;
            base_q  <= '0;
            limit_q <= '0;
            st0_q   <= '0;
            st1_q   <= '0;
            chk_q   <= 1'b0;
        end else if (accept) begin
            op_q    <= '{base_idx: base_idx_i, imm: imm_i, up: up_i,
                         pre: pre_i, wback: wback_i, load: load_i};
            base_q  <= base_val_i;
            limit_q <= limit_i;
            st0_q   <= st_data0_i;
            st1_q   <= st_data1_i;
            chk_q   <= chk_en_i;
        end
    end

    dxg_addr_gen u_addr (
        .base_i  (base_q),
        .imm_i   (op_q.imm),
        .up_i    (op_q.up),
        .pre_i   (op_q.pre),
        .addrs_o (addrs)
    );

    dxg_limit_chk #(.SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_chk (
        .chk_en_i   (chk_q),
        .base_idx_i (op_q.base_idx),
        .wback_i    (op_q.wback),
        .probe_i    (addrs.probe),
        .limit_i    (limit_q),
        .fault_o    (fault),
        .illegal_o  (illegal)
    );

    dxg_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .idle_o       (idle_o),
        .fault_i      (fault),
        .illegal_i    (illegal),
        .load_i       (op_q.load),
        .wback_i      (op_q.wback),
        .addr0_i      (addrs.addr0),
        .addr1_i      (addrs.addr1),
        .new_base_i   (addrs.new_base),
        .st0_i        (st0_q),
        .st1_i        (st1_q),
        .mreq_valid_o (mreq_valid_o),
        .mreq_ready_i (mreq_ready_i),
        .mreq_addr_o  (mreq_addr_o),
        .mreq_we_o    (mreq_we_o),
        .mreq_wdata_o (mreq_wdata_o),
        .mresp_data_i (mresp_data_i),
        .ld_data0_o   (ld_data0_o),
        .ld_data1_o   (ld_data1_o),
        .ld_we0_o     (ld_we0_o),
        .ld_we1_o     (ld_we1_o),
        .wb_data_o    (wb_data_o),
        .wb_en_o      (wb_en_o),
        .done_o       (done_o),
        .stk_fault_o  (stk_fault_o),
        .illegal_o    (illegal_o)
    );

    AST_FAULT_NEEDS_SP_WB: assert property (@(posedge clk) disable iff (rst)
        stk_fault_o |-> $past(accept && chk_en_i && wback_i && (base_idx_i == SP_CODE))); // R3
    AST_WB_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> $past(mreq_valid_o && mreq_ready_i)); // R8
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        ld_we0_o |-> $past(!mreq_we_o)); // R9
endmodule

// File: tb/dxg_top_test.sv
module dxg_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        idle_o;
    logic        chk_en_i = 1'b0;
    logic [3:0]  base_idx_i = '0;
    logic [7:0]  imm_i = '0;
    logic        up_i = 1'b0, pre_i = 1'b0, wback_i = 1'b0, load_i = 1'b0;
    logic [31:0] base_val_i = '0, limit_i = '0, st_data0_i = '0, st_data1_i = '0;
    logic        mreq_valid_o;
    logic        mreq_ready_i = 1'b0;
    logic [31:0] mreq_addr_o;
    logic        mreq_we_o;
    logic [31:0] mreq_wdata_o;
    logic [31:0] mresp_data_i = '0;
    logic [31:0] ld_data0_o, ld_data1_o, wb_data_o;
    logic        ld_we0_o, ld_we1_o, wb_en_o, done_o, stk_fault_o, illegal_o;

    int n_chk = 0;
    int n_fail = 0;
    localparam logic [31:0] RD_KEY = 32'h5A5A_F00F;

    always #5 clk = ~clk;

    dxg_top uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_off(input logic [7:0] imm, input bit up);
        logic [31:0] m;
        m = {22'd0, imm, 2'b00};
        return up ? m : (32'd0 - m);
    endfunction

    task automatic run_op(input bit ce, input logic [3:0] idx, input logic [7:0] imm,
                          input bit up, input bit pre, input bit wb, input bit ld,
                          input logic [31:0] base, input logic [31:0] lim);
        logic [31:0] fin, probe, a0, a1, s0, s1, ea, d0, d1;
        bit e_ill, e_fault, r;
        int nhs;
        fin     = base + ref_off(imm, up);
        probe   = up ? base : fin;                         // R4
        e_ill   = wb && (idx == 4'd15);                    // R7
        e_fault = ce && wb && (idx == 4'd13) && (probe < lim) && !e_ill; // R3 R5
        a0      = pre ? fin : base;                        // R1
        a1      = a0 + 32'd4;                              // R2
        s0 = $urandom; s1 = $urandom;
        d0 = '0; d1 = '0;
        @(negedge clk);
        chk_en_i = ce; base_idx_i = idx; imm_i = imm; up_i = up; pre_i = pre;
        wback_i = wb; load_i = ld; base_val_i = base; limit_i = lim;
        st_data0_i = s0; st_data1_i = s1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!idle_o, "R11 busy after accept", 32'(idle_o), 32'd0);
        check(stk_fault_o == e_fault, "R5 fault decision", 32'(stk_fault_o), 32'(e_fault));
        check(illegal_o == e_ill, "R7 illegal flag", 32'(illegal_o), 32'(e_ill));
        if (e_fault || e_ill) begin
            check(!mreq_valid_o, "R6 no request on abort", 32'(mreq_valid_o), 32'd0);
            @(negedge clk);
            check(idle_o && !mreq_valid_o && !stk_fault_o && !illegal_o && !wb_en_o && !ld_we0_o,
                  "R6 quiet idle after abort", {27'd0, idle_o, mreq_valid_o, stk_fault_o, wb_en_o, ld_we0_o}, 32'h10);
            return;
        end
        nhs = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            mreq_ready_i = 1'b0;
            if (done_o) break;
            if (mreq_valid_o) begin
                r = ($urandom % 3) != 0;
                if (r) begin
                    ea = (nhs == 0) ? a0 : a1;
                    // R10: a stalled request must still carry this address when taken
                    check(mreq_addr_o == ea, (nhs == 0) ? "R1 first address" : "R2 second address", mreq_addr_o, ea);
                    check(mreq_we_o == !ld, "R9 write flag", 32'(mreq_we_o), 32'(!ld));
                    if (!ld) check(mreq_wdata_o == ((nhs == 0) ? s0 : s1), "R9 store data", mreq_wdata_o, (nhs == 0) ? s0 : s1);
                    mresp_data_i = mreq_addr_o ^ RD_KEY;
                    if (nhs == 0) d0 = mresp_data_i; else d1 = mresp_data_i;
                    nhs++;
                end
                mreq_ready_i = r;
            end
        end
        check(done_o && nhs == 2, "R8 completion after two accesses", 32'(nhs), 32'd2);
        check(wb_en_o == wb, "R8 writeback enable", 32'(wb_en_o), 32'(wb));
        if (wb) check(wb_data_o == fin, "R8 writeback value", wb_data_o, fin);
        check(ld_we0_o == ld && ld_we1_o == ld, "R9 load enables", {30'd0, ld_we0_o, ld_we1_o}, {30'd0, ld, ld});
        if (ld) begin
            check(ld_data0_o == d0, "R9 first load word", ld_data0_o, d0);
            check(ld_data1_o == d1, "R9 second load word", ld_data1_o, d1);
        end
        @(negedge clk);
        check(idle_o && !mreq_valid_o, "R11 idle after completion", 32'(idle_o), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lim, base;
        logic [3:0]  idx;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(idle_o && !mreq_valid_o && !stk_fault_o && !done_o, "R11 reset state", 32'(idle_o), 32'd1);

        // R4: start above, end below -> fault
        run_op(1, 4'd13, 8'd4, 0, 1, 1, 0, 32'h2000_0008, 32'h2000_0000);
        // R4: start below, end above -> still faults
        run_op(1, 4'd13, 8'd8, 1, 0, 1, 1, 32'h1FFF_FFFC, 32'h2000_0000);
        // R5: probe equal to limit passes
        run_op(1, 4'd13, 8'd2, 0, 1, 1, 0, 32'h2000_0008, 32'h2000_0000);
        // R5: one word below limit faults
        run_op(1, 4'd13, 8'd3, 0, 1, 1, 1, 32'h2000_0008, 32'h2000_0000);
        // R3: stack base without writeback never faults
        run_op(1, 4'd13, 8'd255, 0, 1, 0, 1, 32'h0000_0100, 32'h8000_0000);
        // R3: checking disabled
        run_op(0, 4'd13, 8'd16, 0, 1, 1, 0, 32'h0000_0010, 32'h8000_0000);
        // R3: other base register
        run_op(1, 4'd5, 8'd16, 0, 1, 1, 1, 32'h0000_0010, 32'h8000_0000);
        // R7: PC base with writeback
        run_op(1, 4'd15, 8'd1, 1, 1, 1, 1, 32'h0000_1000, 32'h0);
        // R1: post-index load, zero immediate subtract
        run_op(1, 4'd13, 8'd0, 0, 0, 1, 1, 32'h3000_0000, 32'h3000_0000);
        // R2: wraparound of second address
        run_op(0, 4'd2, 8'd0, 1, 0, 0, 1, 32'hFFFF_FFFC, 32'h0);

        for (int i = 0; i < 600; i++) begin
            lim  = $urandom;
            base = lim + ($urandom % 2049) - 32'd1024;
            case ($urandom % 4)
                0, 1:    idx = 4'd13;
                2:       idx = 4'd15;
                default: idx = 4'($urandom);
            endcase
            run_op(($urandom % 4) != 0, idx, 8'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), base, lim);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule